// File: doc/BRIEF.md
# Clock Trim and Shared Pin Driver

This block divides a doubled crystal clock down to a one-second tick. It can trim that tick digitally to cancel a known crystal frequency error. `clk_i` runs at twice the crystal rate, so one second is 2^DIV_W cycles; with the default DIV_W of 16 that is 65536 cycles.

Software stores a signed correction code: a magnitude plus a sign. The block splits time into fixed windows of WIN_CYC cycles. At the end of each window it picks up the stored code. Over the next few cycles it either inserts or skips that many divider counts. A sign of 1 inserts counts, which speeds up a slow crystal. A sign of 0 skips counts, which slows down a fast one. With the default window, one magnitude step is about 4.34 ppm.

The same block drives one shared open-drain pin, modelled as a pull-low enable. The pin has three uses:
- **Calibration mode:** a 512 Hz reference tone that the trim does not affect.
- **Square-wave mode:** a selectable square wave.
- **Alarm mode:** an active-low alarm indication.

Top module: `clk_trim_out`

## Requirements
- R1: While `rst_ni` is low, `tick_1hz_o` and `pin_oe_o` are 0, and the stored code, both counters and the window position return to zero.
- R2: With a zero magnitude stored, `tick_1hz_o` is high for exactly one cycle every 2^DIV_W cycles. The first pulse is in the cycle after the 2^DIV_W-th rising edge following reset release.
- R3: At each rising edge where the window position equals WIN_CYC-1, the stored magnitude and sign are latched. Corrections are then applied on the next `magnitude` edges, one count per edge. No correction is applied on the edge that does the latching.
- R4: On a correction edge with the latched sign at 1, the divider advances by 2 instead of 1. A wrap still raises `tick_1hz_o` on the following cycle.
- R5: On a correction edge with the latched sign at 0, the divider holds its value for that edge.
- R6: The stored code takes `cal_mag_i` and `cal_sign_i` only on an edge where `cal_wr_i` and `cal_en_i` are both 1. A write strobe with `cal_en_i` at 0 is ignored.
- R7: While `cal_en_i` is 1, the pin carries the 512 Hz tone: `pin_oe_o` is high while bit 6 of an untrimmed free-running cycle counter is 0. This holds whatever `sqw_en_i` is, since calibration mode has priority.
- R8: With `cal_en_i` at 0 and `sqw_en_i` at 1, `freq_sel_i` chooses the square wave: 0 = 1 Hz, 1 = 512 Hz, 2 = 4096 Hz, 3 = 32768 Hz.
  - The 1 Hz wave comes from the MSB of the trimmed divider.
  - The other three come from bits 6, 3 and 0 of the untrimmed counter.
  - `pin_oe_o` is high while the chosen bit is 0.
- R9: With `cal_en_i` and `sqw_en_i` both 0, `pin_oe_o` equals `alarm_match_i` one cycle earlier, so the pin is pulled low while the alarm is matched.
- R10: `pin_oe_o` is registered. Any change of mode, selection or alarm input shows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the crystal rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_en_i | input | 1 | Calibration mode enable |
| cal_wr_i | input | 1 | Write strobe for the correction code |
| cal_mag_i | input | MAG_W | Correction magnitude |
| cal_sign_i | input | 1 | Correction sign: 1 inserts counts, 0 skips counts |
| sqw_en_i | input | 1 | Square-wave mode enable |
| freq_sel_i | input | 2 | Square-wave frequency select |
| alarm_match_i | input | 1 | Alarm comparator match |
| tick_1hz_o | output | 1 | Trimmed one-second pulse |
| pin_oe_o | output | 1 | Pull-low enable for the shared open-drain pin |

## Verification
Each result has a fixed due time.
- The tick appears one cycle after the rising edge at which the divider wraps.
- A code write reaches the window on the next window end, and the first correction falls on the edge after that.
- The pin drive appears one cycle after the edge that samples the mode, selection and alarm inputs.

A reference model in the bench steps on every rising edge. At each edge it queues the tick and pin levels that the design registers on that edge. The monitor pops that entry at the next falling edge and compares it there, so every comparison lands exactly one register delay after its cause.

// File: rtl/clk_trim_pkg.sv
package clk_trim_pkg;

  typedef enum logic [1:0] {
    FSEL_1HZ  = 2'd0,
    FSEL_512  = 2'd1,
    FSEL_4K   = 2'd2,
    FSEL_32K  = 2'd3
  } freq_sel_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } step_e;

  // untrimmed counter taps, clock at 65536 Hz
  localparam int unsigned TAP_512 = 6;
  localparam int unsigned TAP_4K  = 3;
  localparam int unsigned TAP_32K = 0;
  localparam int unsigned RAW_W   = TAP_512 + 1;

endpackage

// File: rtl/trim_code_reg.sv
module trim_code_reg #(
  parameter int unsigned MAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cal_en_i,
  input  logic             wr_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             sign_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             sign_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_o  <= '0;
      sign_o <= 1'b0;
    end else if (wr_i && cal_en_i) begin
      mag_o  <= mag_i;
      sign_o <= sign_i;
    end
  end

endmodule

// File: rtl/trim_window.sv
module trim_window
  import clk_trim_pkg::*;
#(
  parameter int unsigned MAG_W   = 5,
  parameter int unsigned WIN_CYC = 230400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             sign_i,
  output step_e            step_o,
  output logic             win_end_o,
  output logic [MAG_W-1:0] pend_o
);

  localparam int unsigned WIN_W = $clog2(WIN_CYC);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0] win_q;
  logic [MAG_W-1:0] pend_q;
  logic             psign_q;

  assign win_end_o = (win_q == WIN_LAST);
  assign pend_o    = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else if (win_end_o) win_q <= '0;
    else win_q <= win_q + 1'b1;
  end

  // window must outlast the largest correction burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      psign_q <= 1'b0;
    end else if (win_end_o) begin
      pend_q  <= mag_i;
      psign_q <= sign_i;
    end else if (pend_q != '0) begin
      pend_q  <= pend_q - 1'b1;
    end
  end

  always_comb begin
    if (pend_q == '0) step_o = STEP_ONE;
    else if (psign_q) step_o = STEP_TWO;
    else step_o = STEP_HOLD;
  end

endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import clk_trim_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  step_e step_i,
  output logic  tick_o,
  output logic  sec_phase_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   sum;

  assign sum         = {1'b0, cnt_q} + (DIV_W + 1)'(step_i);
  assign sec_phase_o = cnt_q[DIV_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= sum[DIV_W-1:0];
      tick_o <= sum[DIV_W];
    end
  end

endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import clk_trim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cal_en_i,
  input  logic       sqw_en_i,
  input  logic [1:0] freq_sel_i,
  input  logic       alarm_i,
  input  logic       sec_phase_i,
  output logic       tone_o,
  output logic       pin_oe_o
);

  logic [RAW_W-1:0] raw_q;
  logic             tap;
  logic             oe_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else raw_q <= raw_q + 1'b1;
  end

  assign tone_o = raw_q[TAP_512];

  always_comb begin
    unique case (freq_sel_e'(freq_sel_i))
      FSEL_1HZ: tap = sec_phase_i;
      FSEL_512: tap = raw_q[TAP_512];
      FSEL_4K:  tap = raw_q[TAP_4K];
      FSEL_32K: tap = raw_q[TAP_32K];
      default:  tap = sec_phase_i;
    endcase
  end

  always_comb begin
    if (cal_en_i) oe_d = ~raw_q[TAP_512];
    else if (sqw_en_i) oe_d = ~tap;
    else oe_d = alarm_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_oe_o <= 1'b0;
    else pin_oe_o <= oe_d;
  end

endmodule

// File: rtl/clk_trim_out.sv
module clk_trim_out
  import clk_trim_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned MAG_W   = 5,
  parameter int unsigned WIN_CYC = 230400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cal_en_i,
  input  logic             cal_wr_i,
  input  logic [MAG_W-1:0] cal_mag_i,
  input  logic             cal_sign_i,
  input  logic             sqw_en_i,
  input  logic [1:0]       freq_sel_i,
  input  logic             alarm_match_i,
  output logic             tick_1hz_o,
  output logic             pin_oe_o
);

  logic [MAG_W-1:0] mag_q;
  logic             sign_q;
  logic [MAG_W-1:0] pend;
  logic             win_end;
  logic             sec_phase;
  logic             tone;
  step_e            step;

  trim_code_reg #(.MAG_W(MAG_W)) u_code (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cal_en_i(cal_en_i),
    .wr_i    (cal_wr_i),
    .mag_i   (cal_mag_i),
    .sign_i  (cal_sign_i),
    .mag_o   (mag_q),
    .sign_o  (sign_q)
  );

  trim_window #(.MAG_W(MAG_W), .WIN_CYC(WIN_CYC)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mag_i    (mag_q),
    .sign_i   (sign_q),
    .step_o   (step),
    .win_end_o(win_end),
    .pend_o   (pend)
  );

  tick_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .tick_o     (tick_1hz_o),
    .sec_phase_o(sec_phase)
  );

  pin_mux u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cal_en_i   (cal_en_i),
    .sqw_en_i   (sqw_en_i),
    .freq_sel_i (freq_sel_i),
    .alarm_i    (alarm_match_i),
    .sec_phase_i(sec_phase),
    .tone_o     (tone),
    .pin_oe_o   (pin_oe_o)
  );

endmodule

// File: rtl/clk_trim_chk.sv
module clk_trim_chk #(
  parameter int unsigned MAG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cal_en_i,
  input logic             cal_wr_i,
  input logic             sqw_en_i,
  input logic             alarm_match_i,
  input logic             tick_1hz_o,
  input logic             pin_oe_o,
  input logic [MAG_W-1:0] mag_q,
  input logic             sign_q,
  input logic [MAG_W-1:0] pend,
  input logic             win_end,
  input logic             tone
);

  // R2
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_o |=> !tick_1hz_o);

  // R3
  win_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end |=> pend == $past(mag_q));

  // R3
  pend_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend != '0 && !win_end) |=> pend == MAG_W'($past(pend) - 1'b1));

  // R6
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cal_wr_i && cal_en_i) |=> ($stable(mag_q) && $stable(sign_q)));

  // R7
  cal_tone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_en_i |=> pin_oe_o == !$past(tone));

  // R9
  alarm_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cal_en_i && !sqw_en_i) |=> pin_oe_o == $past(alarm_match_i));

endmodule

bind clk_trim_out clk_trim_chk #(.MAG_W(MAG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cal_en_i     (cal_en_i),
  .cal_wr_i     (cal_wr_i),
  .sqw_en_i     (sqw_en_i),
  .alarm_match_i(alarm_match_i),
  .tick_1hz_o   (tick_1hz_o),
  .pin_oe_o     (pin_oe_o),
  .mag_q        (mag_q),
  .sign_q       (sign_q),
  .pend         (pend),
  .win_end      (win_end),
  .tone         (tone)
);

// File: tb/tb_clk_trim_out.sv
module tb_clk_trim_out;

  localparam int DIV_W   = 8;
  localparam int MAG_W   = 5;
  localparam int WIN_CYC = 64;
  localparam int FULL    = 1 << DIV_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cal_en = 1'b0;
  logic             cal_wr = 1'b0;
  logic [MAG_W-1:0] cal_mag = '0;
  logic             cal_sign = 1'b0;
  logic             sqw_en = 1'b0;
  logic [1:0]       freq_sel = 2'd0;
  logic             alarm = 1'b0;
  logic             tick;
  logic             pin_oe;

  always #10 clk = ~clk;

  clk_trim_out #(.DIV_W(DIV_W), .MAG_W(MAG_W), .WIN_CYC(WIN_CYC)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .cal_en_i     (cal_en),
    .cal_wr_i     (cal_wr),
    .cal_mag_i    (cal_mag),
    .cal_sign_i   (cal_sign),
    .sqw_en_i     (sqw_en),
    .freq_sel_i   (freq_sel),
    .alarm_match_i(alarm),
    .tick_1hz_o   (tick),
    .pin_oe_o     (pin_oe)
  );

  typedef struct packed {
    logic tick;
    logic oe;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  int m_cnt = 0, m_raw = 0, m_win = 0, m_pend = 0, m_mag = 0, m_step = 0, m_sum = 0;
  bit m_psgn = 0, m_sgn = 0, m_tap = 0;
  exp_t m_e;
  exp_t got;

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b", cur_req, what, act, exp);
    end
  endtask

  // reference model: expected register outputs of each rising edge
  always @(posedge clk) begin
    if (rst_ni) begin
      if (cal_en) m_e.oe = !m_raw[6];
      else if (sqw_en) begin
        case (freq_sel)
          2'd0: m_tap = (m_cnt >> (DIV_W - 1)) & 1;
          2'd1: m_tap = m_raw[6];
          2'd2: m_tap = m_raw[3];
          default: m_tap = m_raw[0];
        endcase
        m_e.oe = !m_tap;
      end else m_e.oe = alarm;
      m_step = (m_pend != 0) ? (m_psgn ? 2 : 0) : 1;
      m_sum  = m_cnt + m_step;
      m_e.tick = (m_sum >= FULL);
      m_cnt  = m_sum % FULL;
      if (m_win == WIN_CYC - 1) begin
        m_pend = m_mag;
        m_psgn = m_sgn;
        m_win  = 0;
      end else begin
        if (m_pend != 0) m_pend--;
        m_win++;
      end
      if (cal_wr && cal_en) begin
        m_mag = cal_mag;
        m_sgn = cal_sign;
      end
      m_raw = (m_raw + 1) % 128;
      sb_q.push_back(m_e);
    end
  end

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      got = sb_q.pop_front();
      chk("tick_1hz_o", tick, got.tick);
      chk("pin_oe_o", pin_oe, got.oe);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_code(int mag, bit sgn);
    @(negedge clk);
    cal_wr   = 1'b1;
    cal_mag  = MAG_W'(mag);
    cal_sign = sgn;
    @(negedge clk);
    cal_wr   = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("tick_1hz_o reset", tick, 1'b0);
    chk("pin_oe_o reset", pin_oe, 1'b0);
    rst_ni = 1'b1;

    cur_req = "R2";
    run(3 * FULL);

    cur_req = "R9";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      alarm = (i % 3) != 0;
    end
    alarm = 1'b0;

    cur_req = "R8";
    sqw_en = 1'b1;
    for (int f = 0; f < 4; f++) begin
      freq_sel = 2'(f);
      run(FULL + 40);
    end

    cur_req = "R10";
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      freq_sel = 2'(i % 4);
      sqw_en   = (i % 5) != 0;
      alarm    = (i % 2) != 0;
    end
    sqw_en = 1'b1;

    cur_req = "R7";
    cal_en = 1'b1;
    run(300);

    cur_req = "R4";
    write_code(5, 1'b1);
    cal_en = 1'b0;
    sqw_en = 1'b0;
    run(8 * FULL);

    cur_req = "R5";
    cal_en = 1'b1;
    write_code(31, 1'b0);
    cal_en = 1'b0;
    run(8 * FULL);

    cur_req = "R6";
    write_code(0, 1'b1);
    run(4 * FULL);

    cur_req = "R3";
    cal_en = 1'b1;
    write_code(17, 1'b1);
    run(6 * FULL);

    run(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog act=running exp=finished", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule